// File: doc/BRIEF.md
# Round-Robin DMA Channel Arbiter

This block decides which of four DMA channels is handed the bus for its next transfer. Each channel raises a level request. When no transfer is running, the arbiter grants one requesting channel. It chooses by scanning the channels circularly, starting at the channel that currently holds top priority. The grant is registered and stays fixed until the transfer engine pulses `xfer_done_i`.

On that pulse the granted channel falls to the bottom of the order, and the channel after it becomes the new head. Requests that arrive while a transfer is running never preempt it. They are only looked at once the arbiter is idle again. The current ranking is published on `prio_o`, so the transfer engine or a debug view can see it.

Top module: `dma_rr_arbiter`

## Requirements
- R1: After reset `gnt_o` is 0 and `gnt_valid_o` is 0. The order is 0>1>2>3. `prio_o` holds the channel id of rank k in bits [2k+1:2k], rank 0 being highest, so the reset value is 8'hE4.
- R2: While idle with at least one request, the next clock edge grants exactly one requester. It is the first one met when scanning upward (wrapping from 3 to 0) from the head of the order. The other requesters keep waiting.
- R3: While a grant is active and `xfer_done_i` is low, `gnt_o` and `gnt_valid_o` hold their values and changes on `req_i` have no effect.
- R4: `xfer_done_i` high while a grant is active ends it at the next edge, with `gnt_valid_o` and `gnt_o` going to 0. The finished channel becomes lowest and its successor becomes highest, so finishing 0 gives 1>2>3>0 and finishing 3 gives 0>1>2>3.
- R5: The next grant can appear at the earliest one edge after the edge that ended the previous transfer.
- R6: `xfer_done_i` while no grant is active is ignored and leaves `prio_o` unchanged.
- R7: With no request while idle, no grant is issued and `prio_o` does not change.
- R8: A request that is withdrawn before it is granted is never served.
- R9: `gnt_o` is one-hot exactly when `gnt_valid_o` is 1, and is 0 otherwise.
- R10: Requests from channels 0 and 3 together, then channel 1 arriving during channel 0's transfer, are served in the order 0, 1, 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Level request, one bit per channel |
| xfer_done_i | input | 1 | Pulse from the transfer engine marking the end of the granted transfer |
| gnt_o | output | 4 | One-hot registered grant |
| gnt_valid_o | output | 1 | A grant is active |
| prio_o | output | 8 | Current priority order, 2 bits per rank, rank 0 in the low bits |

## Verification
The assertions assume that `xfer_done_i` is a pulse that the engine raises only for the transfer it is running. They also assume the engine drops it before the arbiter reaches its next idle cycle, so that a fresh grant is not ended at once. The done check only counts on `xfer_done_i` having no effect while idle. The directed tasks keep to these assumptions: they raise the done input for exactly one edge during a grant, and deliberately pulse it only while idle to check that it is ignored. Requests are changed freely, including during transfers and just before a transfer ends, because the arbiter must tolerate any request pattern.

// File: rtl/dma_rr_pkg.sv
package dma_rr_pkg;

  // channel that follows idx in cyclic order
  function automatic int unsigned rr_succ(input int unsigned idx, input int unsigned n);
    return (idx + 1 == n) ? 0 : idx + 1;
  endfunction

  // channel sitting k places after head, wrapping at n
  function automatic int unsigned rr_offset(input int unsigned head, input int unsigned k,
                                            input int unsigned n);
    return (head + k >= n) ? head + k - n : head + k;
  endfunction

endpackage

// File: rtl/rr_select.sv
module rr_select #(
  parameter int NUM_CH = 4,
  parameter int PTR_W  = 2
) (
  input  logic [PTR_W-1:0]  head_i,
  input  logic [NUM_CH-1:0] req_i,
  output logic              found_o,
  output logic [PTR_W-1:0]  win_o
);
  import dma_rr_pkg::*;

  logic [PTR_W-1:0] cand;

  // scan from the far end back to the head so the nearest requester wins
  always_comb begin
    found_o = 1'b0;
    win_o   = '0;
    cand    = '0;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      cand = PTR_W'(rr_offset(32'(head_i), 32'(k), 32'(NUM_CH)));
      if (req_i[cand]) begin
        found_o = 1'b1;
        win_o   = cand;
      end
    end
  end
endmodule

// File: rtl/rr_order_ptr.sv
module rr_order_ptr #(
  parameter int NUM_CH = 4,
  parameter int PTR_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rotate_i,
  input  logic [PTR_W-1:0] fin_idx_i,
  output logic [PTR_W-1:0] head_o
);
  import dma_rr_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      head_o <= '0;
    else if (rotate_i)
      head_o <= PTR_W'(rr_succ(32'(fin_idx_i), 32'(NUM_CH)));
  end
endmodule

// File: rtl/grant_hold.sv
module grant_hold #(
  parameter int NUM_CH = 4,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [PTR_W-1:0]  load_idx_i,
  input  logic              end_i,
  output logic [NUM_CH-1:0] gnt_o,
  output logic              valid_o,
  output logic [PTR_W-1:0]  idx_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_o   <= '0;
      valid_o <= 1'b0;
      idx_o   <= '0;
    end else if (end_i) begin
      gnt_o   <= '0;
      valid_o <= 1'b0;
    end else if (load_i) begin
      gnt_o             <= '0;
      gnt_o[load_idx_i] <= 1'b1;
      valid_o           <= 1'b1;
      idx_o             <= load_idx_i;
    end
  end
endmodule

// File: rtl/dma_rr_arbiter.sv
module dma_rr_arbiter #(
  parameter int NUM_CH = 4,
  localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       req_i,
  input  logic                    xfer_done_i,
  output logic [NUM_CH-1:0]       gnt_o,
  output logic                    gnt_valid_o,
  output logic [NUM_CH*PTR_W-1:0] prio_o
);
  import dma_rr_pkg::*;

  logic [PTR_W-1:0] head_q;
  logic [PTR_W-1:0] win_idx;
  logic [PTR_W-1:0] cur_idx;
  logic             any_req;

  // named internal events
  logic arb_fire;     // idle and a requester exists: grant at next edge
  logic xfer_end;     // active transfer finishes at next edge
  logic done_ignored; // done pulse with nothing granted

  assign arb_fire     = !gnt_valid_o && any_req;
  assign xfer_end     = gnt_valid_o && xfer_done_i;
  assign done_ignored = !gnt_valid_o && xfer_done_i;

  rr_select #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_sel (
    .head_i (head_q),
    .req_i  (req_i),
    .found_o(any_req),
    .win_o  (win_idx)
  );

  grant_hold #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (arb_fire),
    .load_idx_i(win_idx),
    .end_i     (xfer_end),
    .gnt_o     (gnt_o),
    .valid_o   (gnt_valid_o),
    .idx_o     (cur_idx)
  );

  rr_order_ptr #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .rotate_i (xfer_end),
    .fin_idx_i(cur_idx),
    .head_o   (head_q)
  );

  for (genvar r = 0; r < NUM_CH; r++) begin : g_rank
    assign prio_o[r*PTR_W +: PTR_W] = PTR_W'(rr_offset(32'(head_q), 32'(r), 32'(NUM_CH)));
  end
endmodule

// File: rtl/dma_rr_arbiter_chk.sv
module dma_rr_arbiter_chk #(
  parameter int NUM_CH = 4,
  parameter int PTR_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] req_i,
  input logic              xfer_done_i,
  input logic [NUM_CH-1:0] gnt_o,
  input logic              gnt_valid_o,
  input logic [PTR_W-1:0]  head_q,
  input logic              xfer_end,
  input logic              done_ignored
);
  logic [PTR_W-1:0] gnt_next;

  // successor of the granted channel, decoded from the one-hot grant
  always_comb begin
    gnt_next = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (gnt_o[i]) gnt_next = (i == NUM_CH - 1) ? '0 : PTR_W'(i + 1);
  end

  // R9
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o |-> $countones(gnt_o) == 1);

  // R9
  gnt_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid_o |-> gnt_o == '0);

  // R2
  gnt_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid_o && req_i != '0) |=> (gnt_valid_o && (gnt_o & $past(req_i)) != '0));

  // R3
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && !xfer_done_i) |=> (gnt_valid_o && $stable(gnt_o)));

  // R4
  rotate_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> (!gnt_valid_o && head_q == $past(gnt_next)));

  // R6
  done_idle_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ignored |=> $stable(head_q));

  // R7
  no_req_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid_o && req_i == '0) |=> (!gnt_valid_o && $stable(head_q)));
endmodule

bind dma_rr_arbiter dma_rr_arbiter_chk #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .xfer_done_i (xfer_done_i),
  .gnt_o       (gnt_o),
  .gnt_valid_o (gnt_valid_o),
  .head_q      (head_q),
  .xfer_end    (xfer_end),
  .done_ignored(done_ignored)
);

// File: tb/dma_rr_arbiter_tb.sv
module dma_rr_arbiter_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic       done = 1'b0;
  logic [3:0] gnt;
  logic       gv;
  logic [7:0] prio;

  int checks = 0;
  int fails  = 0;
  int exp_head = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_rr_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .xfer_done_i(done),
    .gnt_o(gnt), .gnt_valid_o(gv), .prio_o(prio)
  );

  function automatic logic [7:0] order_of(input int h);
    logic [7:0] v;
    for (int r = 0; r < 4; r++) v[r*2 +: 2] = 2'((h + r) % 4);
    return v;
  endfunction

  function automatic logic [3:0] pick(input logic [3:0] r, input int h);
    for (int k = 0; k < 4; k++)
      if (r[(h + k) % 4]) return 4'b0001 << ((h + k) % 4);
    return 4'b0000;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // end the active transfer and update the model
  task automatic finish_xfer();
    int idx = 0;
    for (int i = 0; i < 4; i++) if (gnt[i]) idx = i;
    done = 1'b1;
    tick();
    done = 1'b0;
    exp_head = (idx + 1) % 4;
    chk("R4 valid", 32'(gv), 0);
    chk("R4 order", 32'(prio), 32'(order_of(exp_head)));
  endtask

  task automatic t_reset();
    chk("R1 gnt", 32'(gnt), 0);
    chk("R1 valid", 32'(gv), 0);
    chk("R1 order", 32'(prio), 32'h E4);
  endtask

  task automatic t_idle();
    req = '0;
    tick();
    chk("R7 valid", 32'(gv), 0);
    chk("R7 order", 32'(prio), 32'(order_of(exp_head)));
    done = 1'b1;
    tick();
    done = 1'b0;
    chk("R6 valid", 32'(gv), 0);
    chk("R6 order", 32'(prio), 32'(order_of(exp_head)));
  endtask

  task automatic t_sequence();
    req = 4'b1001;
    tick();
    chk("R10 first", 32'(gnt), 32'h1);
    req = 4'b1011;
    tick();
    chk("R3 hold", 32'(gnt), 32'h1);
    req = 4'b1010;
    finish_xfer();
    chk("R4 after0", 32'(prio), 32'h39);
    tick();
    chk("R5 second", 32'(gnt), 32'h2);
    req = 4'b1000;
    finish_xfer();
    chk("R4 after1", 32'(prio), 32'h4E);
    tick();
    chk("R10 third", 32'(gnt), 32'h8);
    req = 4'b0000;
    finish_xfer();
    chk("R4 wrap", 32'(prio), 32'hE4);
  endtask

  task automatic t_dropped();
    req = 4'b0010;
    tick();
    chk("R2 grant1", 32'(gnt), 32'h2);
    req = 4'b1010;
    tick();
    req = 4'b0000;
    finish_xfer();
    tick();
    chk("R8 dropped", 32'(gv), 0);
  endtask

  task automatic t_sweep();
    for (int p = 1; p < 16; p++) begin
      req = 4'(p);
      tick();
      chk("R2 sweep", 32'(gnt), 32'(pick(4'(p), exp_head)));
      chk("R9 valid", 32'(gv), 1);
      req = 4'(~p);
      tick();
      chk("R3 sweep", 32'(gnt), 32'(pick(4'(p), exp_head)));
      finish_xfer();
      req = '0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_idle();
    t_sequence();
    t_dropped();
    t_idle();
    t_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule